// File: doc/BRIEF.md
# Masked Software Peripheral Reset Control

This block lets software hold any of seven peripheral units in reset. It keeps a 7-bit control register. Each bit is active low and drives the reset line of one unit directly. A second 7-bit enable register decides which control bits a write may change. Control bits whose enable bit is clear keep their old value whatever is written, so a driver that owns only some units cannot disturb the others.

Both registers are written through plain write strobes with data and can be read back at any time. On a system reset, every control bit returns to one, so no unit is held in reset. Every enable bit also returns to one, so all control bits are writable after reset. Synchronising the reset into each peripheral's clock domain and stretching it belong to other blocks.

Top module: `periph_swrst`

## Requirements
- R1: While and after system reset, and before any write, `ctrl_rd_o` and `unit_rst_no` are all ones (7'h7f).
- R2: While and after system reset, and before any write, `mask_rd_o` is all ones (7'h7f).
- R3: A control write changes the stored control value to (old AND NOT enable) OR (written AND enable), visible on `ctrl_rd_o` after the clock edge that samples the write.
- R4: `unit_rst_no[i]` always equals stored control bit i. The unit order by index is: 0 SPI device, 1 SPI host 0, 2 SPI host 1, 3 USB, 4 I2C 0, 5 I2C 1, 6 I2C 2.
- R5: An enable write replaces all seven enable bits with the written value, readable on `mask_rd_o` after the sampling edge.
- R6: When a control write and an enable write fall in the same cycle, the control write is qualified by the enable value held before that cycle. The new enable value applies from the next write on.
- R7: In a cycle with no write strobe, both stored registers and the outputs keep their values.
- R8: With the enable at 7'h6a and the control at 7'h7f, writing 7'h78 changes only bits 1, 3, 5 and 6 as allowed, giving 7'h7d.
- R9: With the enable at 7'h00, a control write has no effect on `ctrl_rd_o` or `unit_rst_no`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 7 | Control write data, active-low reset per unit |
| mask_wr_i | input | 1 | Enable register write strobe |
| mask_wdata_i | input | 7 | Enable write data, 1 = bit writable |
| ctrl_rd_o | output | 7 | Stored control value |
| mask_rd_o | output | 7 | Stored enable value |
| unit_rst_no | output | 7 | Active-low reset per unit, order as in R4 |

## Verification
A control write and an enable write can land in the same cycle. The bench provokes this twice. First it raises the enable from all zeros while writing zeros to the control register. Then it drops the enable to zero while writing ones. The scoreboard model applies the enable that was held before the cycle, so the first write must leave the control value untouched and the second must take full effect. In both cases the new enable value must be readable afterwards.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

    // Number of peripheral units under software reset control.
    parameter int unsigned NUM_UNITS = 7;

    // Unit index order (behavioural: neighbours decode by position):
    // 0 SPI device, 1 SPI host 0, 2 SPI host 1, 3 USB, 4..6 I2C 0..2.
    localparam int unsigned UNIT_W = NUM_UNITS;

    typedef logic [UNIT_W-1:0] unit_vec_t;

    // All units released, all bits writable after reset.
    localparam unit_vec_t CTRL_RST_VAL = {UNIT_W{1'b1}};
    localparam unit_vec_t MASK_RST_VAL = {UNIT_W{1'b1}};

    typedef struct packed {
        unit_vec_t bits;
    } reg_state_t;

endpackage

// File: rtl/swrst_mask_reg.sv
module swrst_mask_reg
    import swrst_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      wr_i,
    input  unit_vec_t wdata_i,
    output unit_vec_t mask_o
);

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.bits = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.bits <= MASK_RST_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o = state_q.bits;

    AST_MASK_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (mask_o == $past(wdata_i))); // R5

    AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(mask_o)); // R7

endmodule

// File: rtl/swrst_ctrl_reg.sv
module swrst_ctrl_reg
    import swrst_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      wr_i,
    input  unit_vec_t wdata_i,
    input  unit_vec_t mask_i,
    output unit_vec_t ctrl_o
);

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            for (int b = 0; b < int'(UNIT_W); b++) begin
                if (mask_i[b]) begin
                    state_d.bits[b] = wdata_i[b];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.bits <= CTRL_RST_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_o = state_q.bits;

    AST_LOCKED_BITS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((ctrl_o & ~$past(mask_i)) == ($past(ctrl_o) & ~$past(mask_i)))); // R3

    AST_OPEN_BITS_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((ctrl_o & $past(mask_i)) == ($past(wdata_i) & $past(mask_i)))); // R3

    AST_CTRL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(ctrl_o)); // R7

    AST_NO_MASK_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i == '0) |=> $stable(ctrl_o)); // R9

endmodule

// File: rtl/swrst_out_stage.sv
module swrst_out_stage
    import swrst_pkg::*;
(
    input  unit_vec_t ctrl_i,
    output unit_vec_t unit_rst_no
);

    // One active-low reset line per unit, taken straight from its stored bit.
    for (genvar u = 0; u < int'(UNIT_W); u++) begin : g_unit
        assign unit_rst_no[u] = ctrl_i[u];
    end

endmodule

// File: rtl/periph_swrst.sv
module periph_swrst
    import swrst_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 ctrl_wr_i,
    input  logic [NUM_UNITS-1:0] ctrl_wdata_i,
    input  logic                 mask_wr_i,
    input  logic [NUM_UNITS-1:0] mask_wdata_i,
    output logic [NUM_UNITS-1:0] ctrl_rd_o,
    output logic [NUM_UNITS-1:0] mask_rd_o,
    output logic [NUM_UNITS-1:0] unit_rst_no
);

    unit_vec_t mask_q;
    unit_vec_t ctrl_q;

    // The control write sees the enable value held before this cycle.
    swrst_mask_reg u_mask (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (mask_wr_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask_q)
    );

    swrst_ctrl_reg u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (ctrl_wr_i),
        .wdata_i (ctrl_wdata_i),
        .mask_i  (mask_q),
        .ctrl_o  (ctrl_q)
    );

    swrst_out_stage u_out (
        .ctrl_i      (ctrl_q),
        .unit_rst_no (unit_rst_no)
    );

    assign ctrl_rd_o = ctrl_q;
    assign mask_rd_o = mask_q;

    AST_OUT_MATCHES_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unit_rst_no == ctrl_rd_o); // R4

    AST_SAME_CYCLE_OLD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr_i && mask_wr_i) |=>
            ((ctrl_rd_o & ~$past(mask_rd_o)) == ($past(ctrl_rd_o) & ~$past(mask_rd_o)))); // R6

    AST_RESET_RELEASES: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> ((ctrl_rd_o == CTRL_RST_VAL) && (mask_rd_o == MASK_RST_VAL))); // R1

endmodule

// File: tb/tb_periph_swrst.sv
module tb_periph_swrst;

    localparam int N = 7;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         ctrl_wr_i = 1'b0;
    logic [N-1:0] ctrl_wdata_i = '0;
    logic         mask_wr_i = 1'b0;
    logic [N-1:0] mask_wdata_i = '0;
    logic [N-1:0] ctrl_rd_o;
    logic [N-1:0] mask_rd_o;
    logic [N-1:0] unit_rst_no;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [N-1:0] ctrl;
        logic [N-1:0] mask;
        string        req;
    } exp_t;

    exp_t         sb_q[$];
    logic [N-1:0] m_ctrl = 7'h7f;
    logic [N-1:0] m_mask = 7'h7f;

    always #5 clk_i = ~clk_i;

    periph_swrst dut (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ctrl_wr_i    (ctrl_wr_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .mask_wr_i    (mask_wr_i),
        .mask_wdata_i (mask_wdata_i),
        .ctrl_rd_o    (ctrl_rd_o),
        .mask_rd_o    (mask_rd_o),
        .unit_rst_no  (unit_rst_no)
    );

    task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, model update, expected item pushed.
    task automatic op(logic cw, logic [N-1:0] cd, logic mw, logic [N-1:0] md, string req);
        exp_t e;
        @(negedge clk_i);
        ctrl_wr_i    = cw;
        ctrl_wdata_i = cd;
        mask_wr_i    = mw;
        mask_wdata_i = md;
        @(posedge clk_i);
        if (cw) m_ctrl = (m_ctrl & ~m_mask) | (cd & m_mask);
        if (mw) m_mask = md;
        e.ctrl = m_ctrl;
        e.mask = m_mask;
        e.req  = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compares outputs against queued expectations away from the edge.
    initial begin
        forever begin
            @(negedge clk_i);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, "ctrl_rd_o", ctrl_rd_o, e.ctrl);
                check(e.req, "mask_rd_o", mask_rd_o, e.mask);
                check("R4", "unit_rst_no", unit_rst_no, e.ctrl);
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1", "ctrl in reset", ctrl_rd_o, 7'h7f);
        check("R1", "outputs in reset", unit_rst_no, 7'h7f);
        check("R2", "mask in reset", mask_rd_o, 7'h7f);
        rst_ni = 1'b1;

        op(1'b0, 7'h00, 1'b0, 7'h00, "R7");
        op(1'b1, 7'h00, 1'b0, 7'h00, "R3");
        op(1'b1, 7'h7f, 1'b0, 7'h00, "R3");
        // R4: walk one asserted reset across every unit position
        for (int i = 0; i < N; i++) begin
            op(1'b1, ~(7'h01 << i), 1'b0, 7'h00, "R4");
        end
        op(1'b1, 7'h7f, 1'b0, 7'h00, "R3");
        op(1'b0, 7'h00, 1'b1, 7'h6a, "R5");
        op(1'b1, 7'h78, 1'b0, 7'h00, "R8");
        op(1'b0, 7'h00, 1'b0, 7'h00, "R7");
        op(1'b1, 7'h2a, 1'b0, 7'h00, "R3");
        op(1'b0, 7'h00, 1'b1, 7'h00, "R5");
        op(1'b1, 7'h00, 1'b0, 7'h00, "R9");
        op(1'b1, 7'h55, 1'b0, 7'h00, "R9");
        // R6: simultaneous writes, old enable governs
        op(1'b1, 7'h00, 1'b1, 7'h7f, "R6");
        op(1'b1, 7'h00, 1'b0, 7'h00, "R6");
        op(1'b1, 7'h7f, 1'b1, 7'h00, "R6");
        op(1'b1, 7'h12, 1'b0, 7'h00, "R9");
        op(1'b0, 7'h00, 1'b1, 7'h7f, "R5");
        op(1'b1, 7'h55, 1'b1, 7'h0f, "R6");
        op(1'b0, 7'h00, 1'b0, 7'h00, "R7");

        // Mid-run system reset restores both registers.
        @(negedge clk_i);
        @(negedge clk_i);
        ctrl_wr_i = 1'b0;
        mask_wr_i = 1'b0;
        rst_ni    = 1'b0;
        m_ctrl    = 7'h7f;
        m_mask    = 7'h7f;
        @(negedge clk_i);
        check("R1", "ctrl after reset", ctrl_rd_o, 7'h7f);
        check("R1", "outputs after reset", unit_rst_no, 7'h7f);
        check("R2", "mask after reset", mask_rd_o, 7'h7f);
        rst_ni = 1'b1;
        op(1'b1, 7'h40, 1'b0, 7'h00, "R2");
        op(1'b0, 7'h00, 1'b0, 7'h00, "R7");
        @(negedge clk_i);
        @(negedge clk_i);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule